// File: doc/BRIEF.md
# Two-Output Cascaded Interrupt Aggregator

This block gathers up to 23 interrupt request lines into two parent lines, one for normal service and one for fast service. Software configures each source through a small synchronous register bus. A source can sample its input as a level or as an edge, with either sense. It can be masked off, and a routing bit sends it to one of the two parents. Every input is retimed by a two-flop synchroniser before its level or edge is examined.

Software reads three status views: the raw pending state of all sources, and one masked view per parent output. Latched edges are removed by writing ones to an acknowledge register. A software-trigger register injects pending state by hand. A stored security word is kept for software and controls nothing.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset every register, every status view and both parent outputs are 0.
- R2: Only bits 22:0 carry meaning. Bits 31:23 always read 0, and writes to those bits are ignored.
- R3: Offset 0x04 holds the enable mask and takes a full-value write. Writing ones to offset 0x0C sets the matching enable bits. Writing ones to offset 0x08 clears them. Zero bits in either alias leave enables unchanged, and both aliases read 0.
- R4: A source whose mode bit (offset 0x10) is 0 is a level source. It is pending while its synchronised input differs from its polarity bit (offset 0x14): polarity 1 means active-low. Writing to the acknowledge register does not clear it.
- R5: A source whose mode bit is 1 is an edge source. With polarity 0 a rising edge latches it pending, and with polarity 1 a falling edge does. The latch stays set after the input returns.
- R6: Writing ones to offset 0x28 clears the matching latched edges, and that offset reads 0. An edge that is detected in the same cycle as its acknowledge stays latched.
- R7: A route bit of 1 (offset 0x00) steers the source to the fast output `irq_fast_o`. A route bit of 0 steers it to the normal output `irq_norm_o`.
- R8: Offset 0x1C reads pending & enable & ~route, and offset 0x20 reads pending & enable & route.
- R9: Offset 0x24 reads the pending state of every source, regardless of its enable or route bit.
- R10: Offset 0x2C is a software-trigger register. A 1 there is ORed into the matching source's pending state until software writes that bit back to 0. The register reads back its stored value.
- R11: Each parent output is a register holding the OR of its masked status view. When an input changes, the change shows in raw status after two clock edges and on the parent output after the third.
- R12: Offset 0x18 stores a security word that reads back masked to 23 bits and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 23 | Asynchronous interrupt source lines |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of `bus_addr` |
| irq_norm_o | output | 1 | Normal parent interrupt |
| irq_fast_o | output | 1 | Fast parent interrupt |

## Verification
Two functions can act in the same cycle: a new edge reaching the latch, and software acknowledging that same source. The bench first leaves an edge source latched and lets its input return to idle. It then starts a second qualifying edge and times an acknowledge write so that the write lands on the clock edge where the synchronised edge is detected. The design is judged correct only if raw status still shows the source pending afterwards. A plain acknowledge with no edge must then clear it, which shows that the outcome comes from the collision and not from a broken clear.

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
  parameter int NSRC = 23,
  parameter int AW   = 6,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_norm_o,
  output logic            irq_fast_o
);

  localparam logic [AW-1:0] OFS_ROUTE  = AW'(8'h00);
  localparam logic [AW-1:0] OFS_ENABLE = AW'(8'h04);
  localparam logic [AW-1:0] OFS_EN_CLR = AW'(8'h08);
  localparam logic [AW-1:0] OFS_EN_SET = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_MODE   = AW'(8'h10);
  localparam logic [AW-1:0] OFS_POL    = AW'(8'h14);
  localparam logic [AW-1:0] OFS_SECURE = AW'(8'h18);
  localparam logic [AW-1:0] OFS_NSTAT  = AW'(8'h1C);
  localparam logic [AW-1:0] OFS_FSTAT  = AW'(8'h20);
  localparam logic [AW-1:0] OFS_RAW    = AW'(8'h24);
  localparam logic [AW-1:0] OFS_ACK    = AW'(8'h28);
  localparam logic [AW-1:0] OFS_SWTRIG = AW'(8'h2C);

  logic [NSRC-1:0] sync1, sync2, prev;
  logic [NSRC-1:0] route, en, mode, pol, secure, swtrig, lat;
  logic [NSRC-1:0] wd, edge_hit, pend, nstat, fstat;
  logic            unused_wdata_hi;

  assign wd              = bus_wdata[NSRC-1:0];
  assign unused_wdata_hi = ^bus_wdata[DW-1:NSRC];

  assign edge_hit = mode & ((sync2 & ~prev & ~pol) | (~sync2 & prev & pol));
  assign pend     = (mode & lat) | (~mode & (sync2 ^ pol)) | swtrig;
  assign nstat    = pend & en & ~route;
  assign fstat    = pend & en & route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; prev <= '0;
      route <= '0; en <= '0; mode <= '0; pol <= '0;
      secure <= '0; swtrig <= '0; lat <= '0;
      irq_norm_o <= 1'b0; irq_fast_o <= 1'b0;
    end else begin
      sync1 <= src_i;
      sync2 <= sync1;
      prev  <= sync2;
      lat   <= ((lat & ~((bus_we && bus_addr == OFS_ACK) ? wd : '0)) | edge_hit) & mode;
      irq_norm_o <= |nstat;
      irq_fast_o <= |fstat;
      if (bus_we) begin
        case (bus_addr)
          OFS_ROUTE:  route  <= wd;
          OFS_ENABLE: en     <= wd;
          OFS_EN_SET: en     <= en | wd;
          OFS_EN_CLR: en     <= en & ~wd;
          OFS_MODE:   mode   <= wd;
          OFS_POL:    pol    <= wd;
          OFS_SECURE: secure <= wd;
          OFS_SWTRIG: swtrig <= wd;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_ROUTE:  bus_rdata = DW'(route);
      OFS_ENABLE: bus_rdata = DW'(en);
      OFS_MODE:   bus_rdata = DW'(mode);
      OFS_POL:    bus_rdata = DW'(pol);
      OFS_SECURE: bus_rdata = DW'(secure);
      OFS_NSTAT:  bus_rdata = DW'(nstat);
      OFS_FSTAT:  bus_rdata = DW'(fstat);
      OFS_RAW:    bus_rdata = DW'(pend);
      OFS_SWTRIG: bus_rdata = DW'(swtrig);
      default:    bus_rdata = '0;
    endcase
  end

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NSRC] == '0);

  a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_EN_SET) |=> ((en & $past(wd)) == $past(wd)));

  a_r3_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_EN_CLR) |=> ((en & $past(wd)) == '0));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_ACK) |=> ((lat & $past(wd & ~edge_hit)) == '0));

  a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((lat & $past(edge_hit)) == $past(edge_hit)));

  a_r11_norm_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|nstat) |=> irq_norm_o);

  a_r11_norm_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(|nstat) |=> !irq_norm_o);

  a_r7_fast_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|fstat) |=> irq_fast_o);

  a_r7_fast_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fstat) |=> !irq_fast_o);

endmodule

// File: tb/irq_cascade_ctrl_tb_top.sv
module irq_cascade_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] src_i = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_norm_o, irq_fast_o;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  irq_cascade_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clean();
    src_i = '0;
    settle();
    wr(6'h04, 0); wr(6'h10, 0); wr(6'h14, 0); wr(6'h00, 0); wr(6'h2C, 0);
    wr(6'h28, 32'h007F_FFFF);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 12; a++) begin
      rd(6'(a * 4), v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset norm", {31'd0, irq_norm_o}, 0);
    chk("R1 reset fast", {31'd0, irq_fast_o}, 0);
  endtask

  task automatic t_upper();
    logic [31:0] v;
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v);
    chk("R2 enable upper", v, 32'h007F_FFFF);
    wr(6'h00, 32'hFF80_0000); rd(6'h00, v);
    chk("R2 route upper", v, 0);
    clean();
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(6'h04, 32'h0000_0F0F);
    wr(6'h0C, 32'h0000_00F0); rd(6'h04, v);
    chk("R3 set alias", v, 32'h0000_0FFF);
    wr(6'h08, 32'h0000_000F); rd(6'h04, v);
    chk("R3 clr alias", v, 32'h0000_0FF0);
    wr(6'h0C, 0); wr(6'h08, 0); rd(6'h04, v);
    chk("R3 zero bits", v, 32'h0000_0FF0);
    rd(6'h08, v); chk("R3 clr reads 0", v, 0);
    rd(6'h0C, v); chk("R3 set reads 0", v, 0);
    clean();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(6'h04, 32'h0000_0007);
    @(negedge clk); src_i[2] = 1'b1;
    @(negedge clk); v = bus_rdata; bus_addr = 6'h24; #1 v = bus_rdata;
    chk("R11 raw after 1 edge", v & 32'h4, 0);
    @(negedge clk); #1 v = bus_rdata;
    chk("R11 raw after 2 edges", v & 32'h4, 32'h4);
    chk("R11 norm not yet", {31'd0, irq_norm_o}, 0);
    @(negedge clk);
    chk("R11 norm after 3 edges", {31'd0, irq_norm_o}, 1);
    wr(6'h28, 32'h4); settle(); rd(6'h24, v);
    chk("R4 level not acked", v & 32'h4, 32'h4);
    rd(6'h1C, v); chk("R8 nstat level", v, 32'h4);
    src_i[2] = 1'b0; settle(); rd(6'h24, v);
    chk("R4 level follows input", v, 0);
    chk("R4 norm drops", {31'd0, irq_norm_o}, 0);
    wr(6'h14, 32'h2); settle(); rd(6'h24, v);
    chk("R4 active low idle", v, 32'h2);
    src_i[1] = 1'b1; settle(); rd(6'h24, v);
    chk("R4 active low driven high", v, 0);
    clean();
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(6'h10, 32'h18); wr(6'h14, 32'h10); wr(6'h04, 32'h18);
    src_i[3] = 1'b1; settle(); src_i[3] = 1'b0; settle(); rd(6'h24, v);
    chk("R5 rising latched", v & 32'h8, 32'h8);
    src_i[4] = 1'b1; settle(); rd(6'h24, v);
    chk("R5 falling pol ignores rise", v & 32'h10, 0);
    src_i[4] = 1'b0; settle(); rd(6'h24, v);
    chk("R5 falling latched", v & 32'h10, 32'h10);
    chk("R7 normal output", {30'd0, irq_fast_o, irq_norm_o}, 1);
    wr(6'h28, 32'h8); settle(); rd(6'h24, v);
    chk("R6 ack clears one", v, 32'h10);
    rd(6'h28, v); chk("R6 ack reads 0", v, 0);
    clean();
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(6'h10, 32'h40); wr(6'h04, 32'h40);
    src_i[6] = 1'b1; settle(); src_i[6] = 1'b0; settle();
    @(negedge clk); src_i[6] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = 6'h28; bus_wdata = 32'h40; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    settle(); rd(6'h24, v);
    chk("R6 edge wins over ack", v, 32'h40);
    wr(6'h28, 32'h40); settle(); rd(6'h24, v);
    chk("R6 plain ack", v, 0);
    clean();
  endtask

  task automatic t_route();
    logic [31:0] v;
    wr(6'h00, 32'h20); wr(6'h04, 32'h20); wr(6'h2C, 32'h20); settle();
    rd(6'h20, v); chk("R8 fstat", v, 32'h20);
    rd(6'h1C, v); chk("R8 nstat empty", v, 0);
    rd(6'h2C, v); chk("R10 swtrig readback", v, 32'h20);
    chk("R7 fast output", {30'd0, irq_fast_o, irq_norm_o}, 2);
    wr(6'h04, 0); settle();
    rd(6'h24, v); chk("R9 raw ignores enable", v, 32'h20);
    rd(6'h20, v); chk("R8 fstat masked", v, 0);
    chk("R7 fast drops", {31'd0, irq_fast_o}, 0);
    wr(6'h2C, 0); settle(); rd(6'h24, v);
    chk("R10 swtrig removed", v, 0);
    clean();
  endtask

  task automatic t_secure();
    logic [31:0] v;
    wr(6'h18, 32'h1234_5678); settle(); rd(6'h18, v);
    chk("R12 secure readback", v, 32'h0034_5678);
    chk("R12 no output effect", {30'd0, irq_fast_o, irq_norm_o}, 0);
    rd(6'h24, v); chk("R12 no status effect", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_upper();
    t_enable();
    t_level();
    t_edge();
    t_race();
    t_route();
    t_secure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule